// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

A synchronous 1024 x 8 memory with two fully independent ports, left and right. Each port has an active-low select, an active-low write strobe, an active-low output enable, an address and write/read data buses. Either port can read or write any word in any cycle. When both selected ports sit on the same word, an arbiter decides which port owns it. The port that is turned away sees its active-low wait flag, cannot write, and keeps the read data it last returned while the owner writes.

Ownership goes to the port that was on the word first. If one port was already selected on the address and the other becomes selected on it, the port that was there first wins. If both ports were already selected and one of them moves onto the other's address, the port that moved loses. If both arrive in the same cycle, the left port wins. A build-time slave option removes the arbiter. The wait flags then come in as inputs, usually from a master instance on the same address buses, so a wider word made of several banks is arbitrated as one unit.

Top module: `dpram_arbiter`

## Requirements
- R1: Each port can write any of the 1024 words and read it back from either port. Read data is registered and appears on the port one clock after the read is presented.
- R2: Two ports reading the same word in the same cycle both return its contents.
- R3: The wait flags are registered, active low and reset high. A flag is low only in the cycle after both ports were selected on equal addresses, and the two flags are never low together.
- R4: If the addresses match and one port's select was already active on that address, a newly selected port is the one that waits.
- R5: If both selects are active and one port moves onto the other's unchanged address, the moving port is the one that waits.
- R6: The flag returns high one cycle after the addresses stop matching or either select goes inactive.
- R7: A write happens only in a cycle where the port's select and write strobe are both low.
- R8: A port that has lost arbitration cannot write the contested word.
- R9: While a losing port is reading and the owner writes, the loser's read data keeps its previous value. After release the loser returns the new contents.
- R10: With the output enable high, a port's read data reads as zero.
- R11: If both ports land on the same word in the same cycle, the left port wins and the right port waits.
- R12: In slave mode, a low wait input inhibits that port's write and freezes its read data, and the wait outputs stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel_n | input | 1 | Left select, active low |
| l_wr_n | input | 1 | Left write strobe, active low (high = read) |
| l_out_en_n | input | 1 | Left output enable, active low |
| l_addr | input | 10 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data |
| l_wait_n | output | 1 | Left lost arbitration, active low |
| l_wait_in_n | input | 1 | Left external inhibit, active low (tie high on a master) |
| r_sel_n | input | 1 | Right select, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_out_en_n | input | 1 | Right output enable, active low |
| r_addr | input | 10 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data |
| r_wait_n | output | 1 | Right lost arbitration, active low |
| r_wait_in_n | input | 1 | Right external inhibit, active low |

## Verification
The assertions check on every cycle that the two wait flags are never low together, that a flag falls only after a real address match, that both flags are high after a cycle without a match, that a disabled output reads zero, and that slave wait outputs stay high. Which port wins under each arrival order, whether a losing write is dropped, and whether stale read data is held can only be shown by the bench's scenarios. The bench sweeps all 1024 words through both ports and then replays each ordering against values it computes itself.

// File: rtl/dparb_pkg.sv
package dparb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
    } port_ctl_t;

    function automatic port_ctl_t decode_ctl(input logic sel_n, input logic wr_n);
        port_ctl_t c;
        c.sel = ~sel_n;
        c.wr  = ~sel_n & ~wr_n;
        c.rd  = ~sel_n &  wr_n;
        return c;
    endfunction

    // First arrival keeps the word; a fresh simultaneous arrival goes left.
    function automatic owner_e pick_owner(input logic   match,
                                          input owner_e held,
                                          input logic   l_stay,
                                          input logic   r_stay);
        if (!match)
            return OWN_NONE;
        else if (held != OWN_NONE)
            return held;
        else if (r_stay && !l_stay)
            return OWN_RIGHT;
        else
            return OWN_LEFT;
    endfunction

endpackage

// File: rtl/dparb_arbiter.sv
module dparb_arbiter
    import dparb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_sel,
    input  logic          r_sel,
    input  logic [AW-1:0] l_addr,
    input  logic [AW-1:0] r_addr,
    output logic          l_lose,
    output logic          r_lose,
    output logic          l_wait_n,
    output logic          r_wait_n
);

    logic          prev_l_sel, prev_r_sel;
    logic [AW-1:0] prev_l_addr, prev_r_addr;
    owner_e        owner_q, owner_d;
    logic          match, l_stay, r_stay;

    always_comb begin
        match   = l_sel & r_sel & (l_addr == r_addr);
        l_stay  = prev_l_sel & (prev_l_addr == l_addr);
        r_stay  = prev_r_sel & (prev_r_addr == r_addr);
        owner_d = pick_owner(match, owner_q, l_stay, r_stay);
        l_lose  = (owner_d == OWN_RIGHT);
        r_lose  = (owner_d == OWN_LEFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_l_sel  <= 1'b0;
            prev_r_sel  <= 1'b0;
            prev_l_addr <= '0;
            prev_r_addr <= '0;
            owner_q     <= OWN_NONE;
            l_wait_n    <= 1'b1;
            r_wait_n    <= 1'b1;
        end else begin
            prev_l_sel  <= l_sel;
            prev_r_sel  <= r_sel;
            prev_l_addr <= l_addr;
            prev_r_addr <= r_addr;
            owner_q     <= owner_d;
            l_wait_n    <= ~l_lose;
            r_wait_n    <= ~r_lose;
        end
    end

endmodule

// File: rtl/dparb_port.sv
module dparb_port
    import dparb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          sel_n,
    input  logic          wr_n,
    input  logic          out_en_n,
    input  logic          lose,
    input  logic          other_wr,
    input  logic          ext_n,
    input  logic [DW-1:0] q,
    output logic          sel,
    output logic          wr_req,
    output logic          we,
    output logic          re,
    output logic [DW-1:0] rdata
);

    port_ctl_t ctl;
    logic      hold;

    always_comb begin
        ctl    = decode_ctl(sel_n, wr_n);
        sel    = ctl.sel;
        wr_req = ctl.wr;
        hold   = (lose & other_wr) | ~ext_n;
        we     = ctl.wr & ~lose & ext_n;
        re     = ctl.rd & ~hold;
        rdata  = out_en_n ? '0 : q;
    end

endmodule

// File: rtl/dparb_mem.sv
module dparb_mem #(
    parameter int AW = 10,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          l_we,
    input  logic          l_re,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_q,
    input  logic          r_we,
    input  logic          r_re,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_q
);

    logic [DW-1:0] store [DEPTH];

    // Left is written last so it wins if both write one word.
    always_ff @(posedge clk) begin
        if (r_we) store[r_addr] <= r_wdata;
        if (l_we) store[l_addr] <= l_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_q <= '0;
            r_q <= '0;
        end else begin
            if (l_re) l_q <= store[l_addr];
            if (r_re) r_q <= store[r_addr];
        end
    end

endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dparb_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 8,
    parameter bit IS_SLAVE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel_n,
    input  logic              l_wr_n,
    input  logic              l_out_en_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_wait_n,
    input  logic              l_wait_in_n,
    input  logic              r_sel_n,
    input  logic              r_wr_n,
    input  logic              r_out_en_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_wait_n,
    input  logic              r_wait_in_n
);

    logic              l_sel, r_sel, l_wr_req, r_wr_req;
    logic              l_lose, r_lose, l_we, r_we, l_re, r_re;
    logic [DATA_W-1:0] l_q, r_q;

    generate
        if (IS_SLAVE) begin : g_slave
            assign l_lose   = 1'b0;
            assign r_lose   = 1'b0;
            assign l_wait_n = 1'b1;
            assign r_wait_n = 1'b1;
        end else begin : g_master
            dparb_arbiter #(.AW(ADDR_W)) u_arb (
                .clk     (clk),
                .rst     (rst),
                .l_sel   (l_sel),
                .r_sel   (r_sel),
                .l_addr  (l_addr),
                .r_addr  (r_addr),
                .l_lose  (l_lose),
                .r_lose  (r_lose),
                .l_wait_n(l_wait_n),
                .r_wait_n(r_wait_n)
            );
        end
    endgenerate

    dparb_port #(.DW(DATA_W)) u_lport (
        .sel_n   (l_sel_n),
        .wr_n    (l_wr_n),
        .out_en_n(l_out_en_n),
        .lose    (l_lose),
        .other_wr(r_wr_req),
        .ext_n   (l_wait_in_n),
        .q       (l_q),
        .sel     (l_sel),
        .wr_req  (l_wr_req),
        .we      (l_we),
        .re      (l_re),
        .rdata   (l_rdata)
    );

    dparb_port #(.DW(DATA_W)) u_rport (
        .sel_n   (r_sel_n),
        .wr_n    (r_wr_n),
        .out_en_n(r_out_en_n),
        .lose    (r_lose),
        .other_wr(l_wr_req),
        .ext_n   (r_wait_in_n),
        .q       (r_q),
        .sel     (r_sel),
        .wr_req  (r_wr_req),
        .we      (r_we),
        .re      (r_re),
        .rdata   (r_rdata)
    );

    dparb_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .l_we   (l_we),
        .l_re   (l_re),
        .l_addr (l_addr),
        .l_wdata(l_wdata),
        .l_q    (l_q),
        .r_we   (r_we),
        .r_re   (r_re),
        .r_addr (r_addr),
        .r_wdata(r_wdata),
        .r_q    (r_q)
    );

endmodule

// File: rtl/dparb_chk.sv
module dparb_chk #(
    parameter int AW    = 10,
    parameter int DW    = 8,
    parameter bit SLAVE = 1'b0
) (
    input logic          clk,
    input logic          rst,
    input logic          l_sel_n,
    input logic          r_sel_n,
    input logic [AW-1:0] l_addr,
    input logic [AW-1:0] r_addr,
    input logic          l_out_en_n,
    input logic          r_out_en_n,
    input logic [DW-1:0] l_rdata,
    input logic [DW-1:0] r_rdata,
    input logic          l_wait_n,
    input logic          r_wait_n
);

    logic hit;
    assign hit = !l_sel_n && !r_sel_n && (l_addr == r_addr);

    // R3
    wait_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(!l_wait_n && !r_wait_n));

    // R3
    l_fall_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(l_wait_n) |-> $past(hit));

    // R3
    r_fall_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(r_wait_n) |-> $past(hit));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !hit |=> (l_wait_n && r_wait_n));

    // R10
    l_dark_chk: assert property (@(posedge clk) disable iff (rst)
        l_out_en_n |-> (l_rdata == '0));

    // R10
    r_dark_chk: assert property (@(posedge clk) disable iff (rst)
        r_out_en_n |-> (r_rdata == '0));

    generate
        if (SLAVE) begin : g_slv
            // R12
            slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
                l_wait_n && r_wait_n);
        end
    endgenerate

endmodule

bind dpram_arbiter dparb_chk #(.AW(ADDR_W), .DW(DATA_W), .SLAVE(IS_SLAVE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .l_sel_n   (l_sel_n),
    .r_sel_n   (r_sel_n),
    .l_addr    (l_addr),
    .r_addr    (r_addr),
    .l_out_en_n(l_out_en_n),
    .r_out_en_n(r_out_en_n),
    .l_rdata   (l_rdata),
    .r_rdata   (r_rdata),
    .l_wait_n  (l_wait_n),
    .r_wait_n  (r_wait_n)
);

// File: tb/dpram_arbiter_bench.sv
module dpram_arbiter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 8;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          l_sel_n, l_wr_n, l_oe_n, r_sel_n, r_wr_n, r_oe_n;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic          l_wait_n, r_wait_n;

    logic          s_sel_n, s_wr_n, s_ext_n;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wdata, s_rdata, s_r_rdata;
    logic          s_l_wait_n, s_r_wait_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    dpram_arbiter u_dpram_arbiter (
        .clk(clk), .rst(rst),
        .l_sel_n(l_sel_n), .l_wr_n(l_wr_n), .l_out_en_n(l_oe_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .l_wait_n(l_wait_n), .l_wait_in_n(1'b1),
        .r_sel_n(r_sel_n), .r_wr_n(r_wr_n), .r_out_en_n(r_oe_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .r_wait_n(r_wait_n), .r_wait_in_n(1'b1)
    );

    dpram_arbiter #(.IS_SLAVE(1'b1)) u_slave (
        .clk(clk), .rst(rst),
        .l_sel_n(s_sel_n), .l_wr_n(s_wr_n), .l_out_en_n(1'b0),
        .l_addr(s_addr), .l_wdata(s_wdata), .l_rdata(s_rdata),
        .l_wait_n(s_l_wait_n), .l_wait_in_n(s_ext_n),
        .r_sel_n(1'b1), .r_wr_n(1'b1), .r_out_en_n(1'b0),
        .r_addr('0), .r_wdata('0), .r_rdata(s_r_rdata),
        .r_wait_n(s_r_wait_n), .r_wait_in_n(1'b1)
    );

    function automatic logic [DW-1:0] fpat(input int a);
        return DW'((a * 37 + 5) & 255);
    endfunction

    function automatic logic [DW-1:0] gpat(input int a);
        return DW'((a * 13 + 107) & 255);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // sel/wr active high here; idle = deselected read, outputs enabled
    task automatic drv_l(input logic sel, input logic wr, input int a, input logic [DW-1:0] d);
        l_sel_n = ~sel; l_wr_n = ~wr; l_addr = AW'(a); l_wdata = d;
    endtask

    task automatic drv_r(input logic sel, input logic wr, input int a, input logic [DW-1:0] d);
        r_sel_n = ~sel; r_wr_n = ~wr; r_addr = AW'(a); r_wdata = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1: watchdog expired, actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] y;
        drv_l(0, 0, 0, 0); drv_r(0, 0, 0, 0);
        l_oe_n = 1'b0; r_oe_n = 1'b0;
        s_sel_n = 1'b1; s_wr_n = 1'b1; s_ext_n = 1'b1; s_addr = '0; s_wdata = '0;
        repeat (3) tick();
        rst = 1'b0;

        // R3 reset state: flags high, read data zero
        chk("R3 reset l_wait_n", DW'(l_wait_n), 1);
        chk("R3 reset r_wait_n", DW'(r_wait_n), 1);
        chk("R1 reset l_rdata", l_rdata, 0);
        chk("R1 reset r_rdata", r_rdata, 0);

        // R1 full sweep: left writes, right reads
        for (int a = 0; a < WORDS; a++) begin
            drv_l(1, 1, a, fpat(a)); tick();
        end
        drv_l(0, 0, 0, 0);
        for (int a = 0; a < WORDS; a++) begin
            drv_r(1, 0, a, 0); tick();
            chk("R1 right reads left data", r_rdata, fpat(a));
        end
        // R1 full sweep: right writes, left reads
        for (int a = 0; a < WORDS; a++) begin
            drv_r(1, 1, a, gpat(a)); tick();
        end
        drv_r(0, 0, 0, 0);
        for (int a = 0; a < WORDS; a++) begin
            drv_l(1, 0, a, 0); tick();
            chk("R1 left reads right data", l_rdata, gpat(a));
        end
        drv_l(0, 0, 0, 0); tick();

        // R4 select order: left on 100 first, right selects later and tries to write
        drv_l(1, 0, 100, 0); tick();
        chk("R4 no wait before match", DW'(r_wait_n), 1);
        drv_r(1, 1, 100, ~gpat(100)); tick();
        chk("R4 later port waits", DW'(r_wait_n), 0);
        chk("R4 first port free", DW'(l_wait_n), 1);
        tick();
        chk("R3 wait held while matched", DW'(r_wait_n), 0);
        drv_r(1, 0, 100, 0); tick();
        chk("R8 losing write dropped", r_rdata, gpat(100));
        drv_r(0, 0, 0, 0); tick();
        chk("R6 release on deselect", DW'(r_wait_n), 1);
        drv_l(0, 0, 0, 0); tick();

        // R5 address order
        drv_l(1, 0, 200, 0); drv_r(1, 0, 201, 0); tick(); tick();
        drv_r(1, 0, 200, 0); tick();
        chk("R5 mover right waits", DW'(r_wait_n), 0);
        chk("R5 left free", DW'(l_wait_n), 1);
        drv_l(1, 0, 202, 0); tick();
        chk("R6 release on mismatch", DW'(r_wait_n), 1);
        drv_l(1, 0, 200, 0); tick();
        chk("R5 mover left waits", DW'(l_wait_n), 0);
        chk("R5 right now free", DW'(r_wait_n), 1);
        drv_l(0, 0, 0, 0); drv_r(0, 0, 0, 0); tick();

        // R11 tie and R2 shared read
        drv_l(1, 0, 300, 0); drv_r(1, 0, 300, 0); tick();
        chk("R11 tie left free", DW'(l_wait_n), 1);
        chk("R11 tie right waits", DW'(r_wait_n), 0);
        chk("R2 left shared read", l_rdata, gpat(300));
        chk("R2 right shared read", r_rdata, gpat(300));
        drv_l(0, 0, 0, 0); drv_r(0, 0, 0, 0); tick();

        // R9 stale data hold
        y = gpat(401) ^ 8'hFF;
        drv_r(1, 0, 400, 0); drv_l(1, 0, 401, 0); tick();
        chk("R9 setup read", l_rdata, gpat(401));
        drv_l(1, 0, 400, 0); drv_r(1, 1, 400, y); tick();
        chk("R9 left waits", DW'(l_wait_n), 0);
        chk("R9 stale held", l_rdata, gpat(401));
        tick();
        chk("R9 stale still held", l_rdata, gpat(401));
        drv_r(0, 0, 0, 0); tick();
        chk("R9 release", DW'(l_wait_n), 1);
        chk("R9 new data after release", l_rdata, y);
        drv_l(0, 0, 0, 0); tick();

        // R7 strobe without select writes nothing
        drv_l(0, 1, 500, 8'hC3); tick();
        drv_l(1, 0, 500, 0); tick();
        chk("R7 unselected write ignored", l_rdata, gpat(500));

        // R10 output enable
        l_oe_n = 1'b1; tick();
        chk("R10 disabled output zero", l_rdata, 0);
        l_oe_n = 1'b0; #1;
        chk("R10 enabled output", l_rdata, gpat(500));
        drv_l(0, 0, 0, 0); tick();

        // R12 slave mode
        s_sel_n = 1'b0; s_wr_n = 1'b0; s_addr = 5; s_wdata = 8'h11; tick();
        s_addr = 6; s_wdata = 8'h33; tick();
        s_wr_n = 1'b1; tick();
        chk("R12 slave read", s_rdata, 8'h33);
        s_ext_n = 1'b0; s_wr_n = 1'b0; s_addr = 5; s_wdata = 8'h22; tick();
        chk("R12 slave wait out high", DW'(s_l_wait_n), 1);
        s_wr_n = 1'b1; tick();
        chk("R12 slave read frozen", s_rdata, 8'h33);
        s_ext_n = 1'b1; tick();
        chk("R12 slave write inhibited", s_rdata, 8'h11);
        chk("R12 slave right wait high", DW'(s_r_wait_n), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule